// File: doc/BRIEF.md
# Frame-Synchronous PCM Serial Port

This block is a master-mode serial port for a voice-band codec. From its clock input it derives a bit clock and an active-high frame pulse. In each frame it shifts one word out on a serial data pin and takes one word in from a serial data pin, most significant bit first. The word is 8 bits (companded samples) or 16 bits (linear samples). On the parallel side there is a transmit holding register loaded by a strobe and a receive register announced by a one-cycle strobe. Empty, full, underrun and overrun flags report the state of the two registers.

The input `clk` runs at twice the codec master clock, so one `clk` cycle is one master half-period. Three enables are raised in a fixed order: the clock generator first, then the data port, then the frame generator. A controller state machine enforces this order. Its states are `ST_IDLE` (everything stopped), `ST_CLKRUN` (bit clock running), `ST_PORTRDY` (shifters released, no frames) and `ST_FRAMING` (frames running).

Its transitions are:
- gen_en up: IDLE to CLKRUN.
- xr_en up: CLKRUN to PORTRDY.
- fs_en up at a bit-clock rising edge: PORTRDY to FRAMING.
- Any enable dropped: back to the highest state whose enables are all still high. gen_en low goes to IDLE. xr_en low goes to CLKRUN. fs_en low goes from FRAMING to PORTRDY.

Top module: `pcm_serial_port`

## Requirements
- R1: While gen_en is high, bclk is high for div_cfg+1 clk cycles and then low for div_cfg+1 clk cycles, so one bit lasts div_cfg+1 master periods. While gen_en is low, bclk is held low.
- R2: A frame lasts per_cfg+1 bit clocks. fsync_x and fsync_r are driven from one generator and are always equal.
- R3: The frame pulse is high for wid_cfg+1 bit clocks. It changes only in the clk cycle in which bclk goes high.
- R4: Frame pulses appear only when the order has been followed: gen_en, then xr_en, then fs_en. fs_en raised while xr_en is low produces no pulse. Dropping any of the three enables forces fsync low on the next cycle.
- R5: The MSB leaves on sd_out one bit clock after the frame pulse begins. sd_out changes only as bclk rises. sd_oe is high for exactly one word of bit clocks and is low otherwise, meaning the pin floats.
- R6: sd_in is sampled on the falling edge of bclk. When the last bit arrives, rx_valid pulses for one cycle and rx_data holds the word right-justified with the unused upper bits zero.
- R7: lin_mode=0 selects 8-bit words (tx_data[7:0] is sent). lin_mode=1 selects 16-bit words.
- R8: tx_wr loads the holding register and clears tx_empty. At frame start the word is moved into the shifter and tx_empty is set. If no word was written, the previous word is sent again and the sticky flag tx_underrun is set.
- R9: rx_full is set together with rx_valid and cleared by rx_rd. A word that completes while rx_full is high overwrites rx_data and sets the sticky flag rx_overrun.
- R10: While xr_en is low, tx_empty=1 and tx_underrun, rx_full and rx_overrun are all 0. A tx_wr in that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the master clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | DIV_W | Bit-clock divider field |
| per_cfg | input | PER_W | Frame period field (bit clocks minus one) |
| wid_cfg | input | WID_W | Frame pulse width field (bit clocks minus one) |
| lin_mode | input | 1 | 1 selects 16-bit linear, 0 selects 8-bit companded |
| gen_en | input | 1 | Clock generator release |
| xr_en | input | 1 | Transmitter/receiver release |
| fs_en | input | 1 | Frame generator release |
| tx_data | input | 16 | Word to transmit |
| tx_wr | input | 1 | Load strobe for tx_data |
| tx_empty | output | 1 | Holding register is free |
| tx_underrun | output | 1 | Sticky: a frame started without a new word |
| rx_data | output | 16 | Received word, right-justified |
| rx_valid | output | 1 | One-cycle strobe for a new received word |
| rx_full | output | 1 | Unread word present |
| rx_rd | input | 1 | Acknowledge strobe that clears rx_full |
| rx_overrun | output | 1 | Sticky: an unread word was overwritten |
| bclk | output | 1 | Bit clock |
| fsync_x | output | 1 | Transmit frame pulse |
| fsync_r | output | 1 | Receive frame pulse |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Output enable for sd_out |
| sd_in | input | 1 | Serial data in |

## Verification
The bench loops sd_out back to sd_in, so a word sent in a frame must arrive in the same frame. Any error in the one-bit data delay or in the choice of sampling edge then shows up as a shifted or rotated word.

It raises fs_en before xr_en to catch a design that starts framing out of order. It leaves the transmit register unwritten to catch a design that sends stale zeros or fails to flag an underrun. It leaves the receive register unread to catch a design that drops the new word or never sets overrun.

It also runs a second configuration: a pass-through divider, a wider pulse and 16-bit words. A bit or frame counter that is off by one would give wrong pulse widths, wrong enable lengths or wrong frame lengths there.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLKRUN,
        ST_PORTRDY,
        ST_FRAMING
    } pcm_state_e;
endpackage

// File: rtl/pcm_clkgen.sv
module pcm_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             bclk,
    output logic             rise_ev,
    output logic             fall_ev
);
    logic [DIV_W-1:0] half_cnt;
    logic             at_end;

    assign at_end  = run && (half_cnt == div);
    assign rise_ev = at_end && !bclk;
    assign fall_ev = at_end && bclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt <= '0;
            bclk     <= 1'b0;
        end else if (!run) begin
            half_cnt <= '0;
            bclk     <= 1'b0;
        end else if (at_end) begin
            half_cnt <= '0;
            bclk     <= ~bclk;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx import pcm_pkg::*; #(
    parameter int PER_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_on,
    input  logic              framing,
    input  logic              rise_ev,
    input  logic [PER_W-1:0]  nxt_cnt,
    input  logic              wide,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_wr,
    output logic              sd_out,
    output logic              sd_oe,
    output logic              tx_empty,
    output logic              tx_underrun
);
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] src;
    logic [PER_W-1:0]  wlen;
    logic              load_ev;

    assign wlen    = wide ? PER_W'(16) : PER_W'(8);
    assign load_ev = framing && rise_ev && (nxt_cnt == PER_W'(1));
    assign src     = tx_wr ? tx_data : hold_q;
    assign sd_out  = sh_q[WORD_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            sh_q        <= '0;
            sd_oe       <= 1'b0;
            tx_empty    <= 1'b1;
            tx_underrun <= 1'b0;
        end else if (!port_on) begin
            sd_oe       <= 1'b0;
            tx_empty    <= 1'b1;
            tx_underrun <= 1'b0;
        end else if (load_ev) begin
            if (tx_empty && !tx_wr) tx_underrun <= 1'b1;
            if (tx_wr) hold_q <= tx_data;
            sh_q     <= wide ? src : {src[7:0], 8'h00};
            tx_empty <= 1'b1;
            sd_oe    <= 1'b1;
        end else begin
            if (tx_wr) begin
                hold_q   <= tx_data;
                tx_empty <= 1'b0;
            end
            if (!framing) begin
                sd_oe <= 1'b0;
            end else if (rise_ev) begin
                if (nxt_cnt >= PER_W'(2) && nxt_cnt <= wlen) sh_q <= sh_q << 1;
                sd_oe <= (nxt_cnt >= PER_W'(1)) && (nxt_cnt <= wlen);
            end
        end
    end
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx import pcm_pkg::*; #(
    parameter int PER_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_on,
    input  logic              framing,
    input  logic              fall_ev,
    input  logic [PER_W-1:0]  cur_cnt,
    input  logic              wide,
    input  logic              sd_in,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_full,
    output logic              rx_overrun
);
    logic [WORD_W-2:0] rsh_q;
    logic [PER_W-1:0]  wlen;
    logic              bit_ev;
    logic              last_ev;

    assign wlen    = wide ? PER_W'(16) : PER_W'(8);
    assign bit_ev  = framing && fall_ev && (cur_cnt >= PER_W'(1)) && (cur_cnt <= wlen);
    assign last_ev = bit_ev && (cur_cnt == wlen);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsh_q      <= '0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_full    <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!port_on) begin
                rx_full    <= 1'b0;
                rx_overrun <= 1'b0;
            end else begin
                if (bit_ev) rsh_q <= {rsh_q[WORD_W-3:0], sd_in};
                if (last_ev) begin
                    rx_data  <= wide ? {rsh_q, sd_in} : {8'h00, rsh_q[6:0], sd_in};
                    rx_valid <= 1'b1;
                    if (rx_full) rx_overrun <= 1'b1;
                    rx_full  <= 1'b1;
                end else if (rx_rd) begin
                    rx_full <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port import pcm_pkg::*; #(
    parameter int DIV_W = 8,
    parameter int PER_W = 12,
    parameter int WID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_cfg,
    input  logic [PER_W-1:0]  per_cfg,
    input  logic [WID_W-1:0]  wid_cfg,
    input  logic              lin_mode,
    input  logic              gen_en,
    input  logic              xr_en,
    input  logic              fs_en,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_wr,
    output logic              tx_empty,
    output logic              tx_underrun,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_full,
    input  logic              rx_rd,
    output logic              rx_overrun,
    output logic              bclk,
    output logic              fsync_x,
    output logic              fsync_r,
    output logic              sd_out,
    output logic              sd_oe,
    input  logic              sd_in
);
    pcm_state_e       st_q, st_d;
    logic             rise_ev, fall_ev;
    logic [PER_W-1:0] fcnt_q, fcnt_nx, wid_ext;
    logic             fs_q;
    logic             port_on, framing;

    pcm_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(gen_en), .div(div_cfg),
        .bclk(bclk), .rise_ev(rise_ev), .fall_ev(fall_ev)
    );

    // Release-order controller (R4)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (gen_en) st_d = ST_CLKRUN;
            ST_CLKRUN:  if (!gen_en) st_d = ST_IDLE;
                        else if (xr_en) st_d = ST_PORTRDY;
            ST_PORTRDY: if (!gen_en) st_d = ST_IDLE;
                        else if (!xr_en) st_d = ST_CLKRUN;
                        else if (fs_en && rise_ev) st_d = ST_FRAMING;
            ST_FRAMING: if (!gen_en) st_d = ST_IDLE;
                        else if (!xr_en) st_d = ST_CLKRUN;
                        else if (!fs_en) st_d = ST_PORTRDY;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign port_on = (st_d == ST_PORTRDY) || (st_d == ST_FRAMING);
    assign framing = (st_d == ST_FRAMING);
    assign wid_ext = PER_W'(wid_cfg);
    assign fcnt_nx = (st_q == ST_FRAMING) ?
                     ((fcnt_q == per_cfg) ? '0 : fcnt_q + 1'b1) : '0;

    // Frame counter and pulse (R2, R3)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt_q <= '0;
            fs_q   <= 1'b0;
        end else if (!framing) begin
            fcnt_q <= '0;
            fs_q   <= 1'b0;
        end else if (rise_ev) begin
            fcnt_q <= fcnt_nx;
            fs_q   <= (fcnt_nx <= wid_ext);
        end
    end

    assign fsync_x = fs_q;
    assign fsync_r = fs_q;

    pcm_tx #(.PER_W(PER_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .port_on(port_on), .framing(framing),
        .rise_ev(rise_ev), .nxt_cnt(fcnt_nx), .wide(lin_mode),
        .tx_data(tx_data), .tx_wr(tx_wr), .sd_out(sd_out), .sd_oe(sd_oe),
        .tx_empty(tx_empty), .tx_underrun(tx_underrun)
    );

    pcm_rx #(.PER_W(PER_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .port_on(port_on), .framing(framing),
        .fall_ev(fall_ev), .cur_cnt(fcnt_q), .wide(lin_mode), .sd_in(sd_in),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_full(rx_full), .rx_overrun(rx_overrun)
    );
endmodule

// File: rtl/pcm_serial_port_sva.sv
module pcm_serial_port_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        gen_en,
    input logic        xr_en,
    input logic        fs_en,
    input logic        lin_mode,
    input logic        bclk,
    input logic        fsync_x,
    input logic        sd_out,
    input logic        sd_oe,
    input logic        rx_valid,
    input logic        rx_full,
    input logic [15:0] rx_data
);
    assert_bclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !bclk);

    assert_fs_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync_x) |-> $rose(bclk));

    assert_fs_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en || !xr_en || !fs_en) |=> !fsync_x);

    assert_dout_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_oe && $past(sd_oe) && !$stable(sd_out)) |-> $rose(bclk));

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !lin_mode) |-> (rx_data[15:8] == 8'h00));

    assert_full_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_full);
endmodule

bind pcm_serial_port pcm_serial_port_sva u_sva (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .xr_en(xr_en), .fs_en(fs_en),
    .lin_mode(lin_mode), .bclk(bclk), .fsync_x(fsync_x), .sd_out(sd_out),
    .sd_oe(sd_oe), .rx_valid(rx_valid), .rx_full(rx_full), .rx_data(rx_data)
);

// File: tb/pcm_serial_port_test.sv
module pcm_serial_port_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  div_cfg = 0;
    logic [11:0] per_cfg = 0;
    logic [7:0]  wid_cfg = 0;
    logic        lin_mode = 0, gen_en = 0, xr_en = 0, fs_en = 0;
    logic [15:0] tx_data = 0;
    logic        tx_wr = 0, rx_rd = 0;
    logic        tx_empty, tx_underrun, rx_valid, rx_full, rx_overrun;
    logic [15:0] rx_data;
    logic        bclk, fsync_x, fsync_r, sd_out, sd_oe, sd_in;

    int checks = 0, errors = 0;
    bit done = 0;

    assign sd_in = sd_oe ? sd_out : 1'b1;

    always #10 clk = ~clk;

    pcm_serial_port uut (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .per_cfg(per_cfg),
        .wid_cfg(wid_cfg), .lin_mode(lin_mode), .gen_en(gen_en), .xr_en(xr_en),
        .fs_en(fs_en), .tx_data(tx_data), .tx_wr(tx_wr), .tx_empty(tx_empty),
        .tx_underrun(tx_underrun), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_full(rx_full), .rx_rd(rx_rd), .rx_overrun(rx_overrun), .bclk(bclk),
        .fsync_x(fsync_x), .fsync_r(fsync_r), .sd_out(sd_out), .sd_oe(sd_oe),
        .sd_in(sd_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising clock
    int mh, ms, mf, wl, ns, nf;
    bit mb, mfs, mempty, mund, moe, mvalid, mfull, mover;
    bit [15:0] mhold, msh, mrsh, mrx, src;
    always @(posedge clk) begin
        bit edg, rise, fall, port, frm, din;
        if (!rst_n) begin
            mh = 0; mb = 0; ms = 0; mf = 0; mfs = 0; mhold = 0; msh = 0;
            mempty = 1; mund = 0; moe = 0; mrsh = 0; mrx = 0;
            mvalid = 0; mfull = 0; mover = 0;
        end else begin
            edg  = gen_en && (mh == int'(div_cfg));
            rise = edg && !mb;
            fall = edg && mb;
            case (ms)
                0: ns = gen_en ? 1 : 0;
                1: ns = !gen_en ? 0 : (xr_en ? 2 : 1);
                2: ns = !gen_en ? 0 : (!xr_en ? 1 : ((rise && fs_en) ? 3 : 2));
                default: ns = !gen_en ? 0 : (!xr_en ? 1 : (!fs_en ? 2 : 3));
            endcase
            port = ns >= 2;
            frm  = ns == 3;
            wl   = lin_mode ? 16 : 8;
            din  = moe ? msh[15] : 1'b1;
            nf   = (ms == 3) ? ((mf == int'(per_cfg)) ? 0 : mf + 1) : 0;
            if (!gen_en) begin mh = 0; mb = 0; end
            else if (mh == int'(div_cfg)) begin mh = 0; mb = !mb; end
            else mh++;
            mvalid = 0;
            if (!port) begin
                mfull = 0; mover = 0;
            end else if (frm && fall && mf >= 1 && mf <= wl) begin
                mrsh = {mrsh[14:0], din};
                if (mf == wl) begin
                    mrx = (wl == 16) ? mrsh : {8'h00, mrsh[7:0]};
                    mvalid = 1;
                    if (mfull) mover = 1;
                    mfull = 1;
                end else if (rx_rd) mfull = 0;
            end else if (rx_rd) mfull = 0;
            if (!port) begin
                mempty = 1; mund = 0; moe = 0;
            end else if (frm && rise && nf == 1) begin
                if (mempty && !tx_wr) mund = 1;
                src = tx_wr ? tx_data : mhold;
                if (tx_wr) mhold = tx_data;
                msh = (wl == 16) ? src : {src[7:0], 8'h00};
                mempty = 1; moe = 1;
            end else begin
                if (tx_wr) begin mhold = tx_data; mempty = 0; end
                if (!frm) moe = 0;
                else if (rise) begin
                    if (nf >= 2 && nf <= wl) msh = msh << 1;
                    moe = (nf >= 1 && nf <= wl);
                end
            end
            if (!frm) begin mf = 0; mfs = 0; end
            else if (rise) begin mf = nf; mfs = (nf <= int'(wid_cfg)); end
            ms = ns;
        end
    end

    // Per-cycle comparison and run-length measurements
    int fs_count = 0, cyc = 0, last_rise = -1, fs_period = 0;
    int fs_run = 0, fs_hi = 0, oe_run = 0, oe_len = 0, bk_run = 0, bk_hi = 0;
    bit p_fs = 0, p_oe = 0, p_bk = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            chk(bclk == mb, "R1 bclk", bclk, mb);
            chk(fsync_x == mfs && fsync_r == mfs, "R2/R3 fsync", {fsync_x, fsync_r}, {mfs, mfs});
            chk(sd_oe == moe, "R5 sd_oe", sd_oe, moe);
            if (moe) chk(sd_out == msh[15], "R5 sd_out", sd_out, msh[15]);
            chk(tx_empty == mempty && tx_underrun == mund, "R8 tx flags",
                {tx_empty, tx_underrun}, {mempty, mund});
            chk(rx_valid == mvalid, "R6 rx_valid", rx_valid, mvalid);
            if (mvalid) chk(rx_data == mrx, "R6 rx_data", rx_data, mrx);
            chk(rx_full == mfull && rx_overrun == mover, "R9 rx flags",
                {rx_full, rx_overrun}, {mfull, mover});
            if (fsync_x) fs_count++;
            if (fsync_x && !p_fs) begin
                if (last_rise >= 0) fs_period = cyc - last_rise;
                last_rise = cyc;
            end
            fs_run = fsync_x ? fs_run + 1 : 0;
            if (!fsync_x && p_fs) fs_hi = fs_run_prev;
            oe_run = sd_oe ? oe_run + 1 : 0;
            if (!sd_oe && p_oe) oe_len = oe_run_prev;
            bk_run = bclk ? bk_run + 1 : 0;
            if (!bclk && p_bk) bk_hi = bk_run_prev;
            fs_run_prev = fs_run; oe_run_prev = oe_run; bk_run_prev = bk_run;
            p_fs = fsync_x; p_oe = sd_oe; p_bk = bclk;
        end
    end
    int fs_run_prev = 0, oe_run_prev = 0, bk_run_prev = 0;

    task automatic wait_valid(input string tag);
        int n = 0;
        @(negedge clk);
        while (!rx_valid && n < 2000) begin @(negedge clk); n++; end
        if (!rx_valid) chk(0, tag, 0, 1);
    endtask

    task automatic write_tx(input logic [15:0] d);
        @(negedge clk); tx_data = d; tx_wr = 1;
        @(negedge clk); tx_wr = 0;
    endtask

    task automatic read_rx();
        @(negedge clk); rx_rd = 1;
        @(negedge clk); rx_rd = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(bclk == 0 && fsync_x == 0 && sd_oe == 0, "R1 reset outputs", {bclk, fsync_x, sd_oe}, 0);
        chk(tx_empty == 1 && rx_full == 0, "R10 reset flags", {tx_empty, rx_full}, 2);

        // 8-bit mode: bit = 2 master periods, 20 bits per frame, 1-bit pulse
        div_cfg = 1; per_cfg = 19; wid_cfg = 0; lin_mode = 0;
        gen_en = 1;
        repeat (20) @(negedge clk);
        fs_en = 1;                         // out of order: port still held
        repeat (200) @(negedge clk);
        chk(fs_count == 0, "R4 no frames before xr_en", fs_count, 0);
        fs_en = 0;
        write_tx(16'h00A5);
        chk(tx_empty == 1, "R10 write ignored while port held", tx_empty, 1);
        xr_en = 1;
        repeat (3) @(negedge clk);
        write_tx(16'h00A5);
        chk(tx_empty == 0, "R8 write clears empty", tx_empty, 0);
        fs_en = 1;
        wait_valid("R6 first word timeout");
        chk(rx_data == 16'h00A5, "R6 R7 first word", rx_data, 16'h00A5);
        read_rx();
        write_tx(16'h123C);
        wait_valid("R6 second word timeout");
        chk(rx_data == 16'h003C, "R7 upper byte dropped", rx_data, 16'h003C);
        chk(tx_underrun == 0, "R8 no underrun yet", tx_underrun, 0);
        read_rx();
        wait_valid("R8 third word timeout");
        chk(rx_data == 16'h003C, "R8 resend previous", rx_data, 16'h003C);
        chk(tx_underrun == 1, "R8 underrun flagged", tx_underrun, 1);
        write_tx(16'h0081);
        wait_valid("R9 fourth word timeout");
        chk(rx_data == 16'h0081, "R9 overwritten data", rx_data, 16'h0081);
        chk(rx_overrun == 1 && rx_full == 1, "R9 overrun flagged", {rx_overrun, rx_full}, 3);
        chk(fs_period == 80, "R2 frame period", fs_period, 80);
        chk(fs_hi == 4, "R3 pulse width", fs_hi, 4);
        chk(oe_len == 32, "R5 enable length", oe_len, 32);
        chk(bk_hi == 2, "R1 bclk high time", bk_hi, 2);
        xr_en = 0;
        repeat (4) @(negedge clk);
        chk(tx_empty == 1 && tx_underrun == 0, "R10 tx flags cleared", {tx_empty, tx_underrun}, 2);
        chk(rx_full == 0 && rx_overrun == 0, "R10 rx flags cleared", {rx_full, rx_overrun}, 0);
        chk(fsync_x == 0, "R4 frames stop", fsync_x, 0);

        // 16-bit mode: pass-through divider, 32 bits per frame, 3-bit pulse
        fs_en = 0; gen_en = 0;
        @(negedge clk);
        div_cfg = 0; per_cfg = 31; wid_cfg = 2; lin_mode = 1;
        gen_en = 1;
        repeat (4) @(negedge clk);
        xr_en = 1;
        repeat (3) @(negedge clk);
        write_tx(16'hC3A5);
        fs_en = 1;
        wait_valid("R7 linear word timeout");
        chk(rx_data == 16'hC3A5, "R7 linear word", rx_data, 16'hC3A5);
        read_rx();
        write_tx(16'h8001);
        wait_valid("R7 second linear timeout");
        chk(rx_data == 16'h8001, "R7 second linear word", rx_data, 16'h8001);
        chk(fs_period == 64, "R2 frame period linear", fs_period, 64);
        chk(fs_hi == 6, "R3 wide pulse", fs_hi, 6);
        chk(oe_len == 32, "R5 enable length linear", oe_len, 32);
        chk(bk_hi == 1, "R1 pass-through bclk", bk_hi, 1);
        gen_en = 0;
        repeat (3) @(negedge clk);
        chk(bclk == 0 && fsync_x == 0, "R1 R4 stopped", {bclk, fsync_x}, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule